// File: doc/BRIEF.md
# Instruction-Cycle Exception Check Controller

This block runs at the top of every macroinstruction cycle, before fetch and decode. On a start pulse it walks five pending-condition checks in a fixed priority order. The order is trace trap, interrupt request, console halt, odd program counter, then stack-limit violation. It spends one clock per check that is enabled. The first check that finds its condition present ends the walk with a one-cycle, one-hot dispatch pulse that selects that condition's service routine. If no enabled check hits, the walk ends with a one-cycle proceed-to-fetch pulse.

A fast-mode input drops the odd-PC and stack-limit checks from the walk, and their states cost no cycles. A retired return-from-trace instruction arms a one-shot skip of the trace check for the next walk only. The other checks still run in that walk. The block also guards status-word writes: when an instruction whose class writes a destination targets the status word, the trace bit keeps its current value and every other bit takes the new data.

Top module: `exc_check_ctrl`

## Requirements
- R1: After a synchronous reset, `svc_go`, `fetch_go`, `busy` and `psw_we` are all 0.
- R2: The dispatch goes to the highest-priority enabled condition that is present. The `svc_go` bit positions are 0 trace, 1 interrupt, 2 halt, 3 odd PC and 4 stack limit, and lower positions have higher priority. At most one bit is set.
- R3: When no enabled condition is present, `fetch_go` pulses for one cycle. `fetch_go` and `svc_go` are never active together.
- R4: Each enabled check takes one cycle. If the start pulse is sampled at clock edge 0, the dispatch or fetch pulse is visible after edge N, where N is the rank of the hit among the enabled checks, or the count of enabled checks if none hits. The pulse lasts exactly one cycle.
- R5: With `fast_mode` high at start, the odd-PC and stack-limit checks are neither evaluated nor counted in the latency. `svc_go[3]` and `svc_go[4]` never fire in that walk.
- R6: A condition that is bypassed is not remembered. A later normal-mode walk with that input low ends in fetch.
- R7: A `ret_trace` pulse makes the next walk skip only the trace check. The walk after that checks trace again.
- R8: A status-word write updates `psw_next` with the trace bit (bit 4 by default) taken from `psw_now` and all other bits from `dest_data`. The update is visible one cycle after the request, together with `psw_we`.
- R9: `psw_we` is raised only for a request with `dest_wr` high, `dest_psw` high and `op_nodst` low. The no-destination classes (compare, bit test, test) and non-status destinations never raise it.
- R10: A `chk_start` pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_start | input | 1 | Begin the top-of-cycle check walk |
| trace_pend | input | 1 | Trace trap pending |
| irq_pend | input | 1 | Interrupt request pending |
| halt_pend | input | 1 | Console halt pending |
| oddpc_err | input | 1 | Program counter is odd |
| stack_err | input | 1 | Stack limit violated |
| fast_mode | input | 1 | Bypass the odd-PC and stack-limit checks |
| ret_trace | input | 1 | Return-from-trace instruction retired |
| dest_wr | input | 1 | Instruction writes its destination this cycle |
| dest_psw | input | 1 | Destination is the status word |
| op_nodst | input | 1 | Instruction class writes no destination |
| dest_data | input | W | New destination value |
| psw_now | input | W | Current status word |
| svc_go | output | 5 | One-hot service routine dispatch pulse |
| fetch_go | output | 1 | Proceed-to-fetch pulse |
| busy | output | 1 | Check walk in progress |
| psw_we | output | 1 | Status-word write strobe |
| psw_next | output | W | Masked status-word value |

## Verification
The bench tries every combination of the five condition inputs in both modes, with and without a preceding return-from-trace. For each run it compares the dispatch bit and the exact latency against a priority model. A wrong priority order would dispatch to a lower-ranked routine. A fast mode that still spent cycles would show up as extra latency. A skip flag that persisted, or was never consumed, would drop or keep the trace dispatch in the wrong walk. Directed cases also cover a bypassed odd-PC condition, a start pulse issued mid-walk, and status writes with either polarity of the trace bit and with the no-destination class. A sticky condition would dispatch later. A restartable walk would produce two pulses. A missing mask would flip the trace bit.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NCHK = 5;
  localparam int IDXW = 3;

  typedef enum logic [IDXW-1:0] {
    CK_TRACE = 3'd0,
    CK_IRQ   = 3'd1,
    CK_HALT  = 3'd2,
    CK_ODD   = 3'd3,
    CK_STACK = 3'd4
  } chk_e;
endpackage

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NCHK-1:0] cond,
  input  logic            fast,
  input  logic            ret_trace,
  output logic [NCHK-1:0] svc,
  output logic            fetch,
  output logic            busy
);
  localparam logic [IDXW-1:0] NONE = IDXW'(NCHK);

  logic            active;
  logic [IDXW-1:0] idx;
  logic [NCHK-1:0] en_q;
  logic [NCHK-1:0] en_new;
  logic            skip_tr;

  // Lowest enabled index at or above 'from', or NONE
  function automatic logic [IDXW-1:0] next_from(input logic [NCHK-1:0] m,
                                                input logic [IDXW-1:0] from);
    logic [IDXW-1:0] r;
    r = NONE;
    for (int i = NCHK - 1; i >= 0; i--) begin
      if (m[i] && (IDXW'(i) >= from)) r = IDXW'(i);
    end
    return r;
  endfunction

  always_comb begin
    en_new           = '1;
    en_new[CK_TRACE] = ~skip_tr;
    en_new[CK_ODD]   = ~fast;
    en_new[CK_STACK] = ~fast;
  end

  logic [IDXW-1:0] nxt;
  assign nxt = next_from(en_q, IDXW'(idx + 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      idx     <= '0;
      en_q    <= '0;
      skip_tr <= 1'b0;
      svc     <= '0;
      fetch   <= 1'b0;
    end else begin
      svc   <= '0;
      fetch <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          en_q    <= en_new;
          idx     <= next_from(en_new, '0);
          skip_tr <= 1'b0;
        end
      end else if (cond[idx]) begin
        svc    <= NCHK'(1) << idx;
        active <= 1'b0;
      end else if (nxt == NONE) begin
        fetch  <= 1'b1;
        active <= 1'b0;
      end else begin
        idx <= nxt;
      end
      if (ret_trace) skip_tr <= 1'b1;
    end
  end

  assign busy = active;
endmodule

// File: rtl/psw_guard.sv
module psw_guard #(
  parameter int W    = 16,
  parameter int TBIT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic         is_psw,
  input  logic         nodst,
  input  logic [W-1:0] data,
  input  logic [W-1:0] now,
  output logic         we_o,
  output logic [W-1:0] next_o
);
  logic [W-1:0] merged;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == TBIT) begin : g_keep
      assign merged[i] = now[i];
    end else begin : g_take
      assign merged[i] = data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we_o   <= 1'b0;
      next_o <= '0;
    end else begin
      we_o <= wr & is_psw & ~nodst;
      if (wr & is_psw & ~nodst) next_o <= merged;
    end
  end
endmodule

// File: rtl/exc_check_ctrl.sv
module exc_check_ctrl
  import exc_pkg::*;
#(
  parameter int W    = 16,
  parameter int TBIT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            chk_start,
  input  logic            trace_pend,
  input  logic            irq_pend,
  input  logic            halt_pend,
  input  logic            oddpc_err,
  input  logic            stack_err,
  input  logic            fast_mode,
  input  logic            ret_trace,
  input  logic            dest_wr,
  input  logic            dest_psw,
  input  logic            op_nodst,
  input  logic [W-1:0]    dest_data,
  input  logic [W-1:0]    psw_now,
  output logic [NCHK-1:0] svc_go,
  output logic            fetch_go,
  output logic            busy,
  output logic            psw_we,
  output logic [W-1:0]    psw_next
);
  logic [NCHK-1:0] cond;

  always_comb begin
    cond           = '0;
    cond[CK_TRACE] = trace_pend;
    cond[CK_IRQ]   = irq_pend;
    cond[CK_HALT]  = halt_pend;
    cond[CK_ODD]   = oddpc_err;
    cond[CK_STACK] = stack_err;
  end

  exc_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (chk_start),
    .cond      (cond),
    .fast      (fast_mode),
    .ret_trace (ret_trace),
    .svc       (svc_go),
    .fetch     (fetch_go),
    .busy      (busy)
  );

  psw_guard #(.W(W), .TBIT(TBIT)) u_psw (
    .clk    (clk),
    .rst    (rst),
    .wr     (dest_wr),
    .is_psw (dest_psw),
    .nodst  (op_nodst),
    .data   (dest_data),
    .now    (psw_now),
    .we_o   (psw_we),
    .next_o (psw_next)
  );
endmodule

// File: rtl/exc_check_ctrl_chk.sv
module exc_check_ctrl_chk #(
  parameter int W    = 16,
  parameter int TBIT = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         chk_start,
  input logic         fast_mode,
  input logic         ret_trace,
  input logic         dest_wr,
  input logic         dest_psw,
  input logic         op_nodst,
  input logic [W-1:0] dest_data,
  input logic [W-1:0] psw_now,
  input logic [4:0]   svc_go,
  input logic         fetch_go,
  input logic         busy,
  input logic         psw_we,
  input logic [W-1:0] psw_next
);
  logic fast_run;
  logic skip_arm;
  logic skip_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_run <= 1'b0;
      skip_arm <= 1'b0;
      skip_run <= 1'b0;
    end else begin
      if (chk_start && !busy) begin
        fast_run <= fast_mode;
        skip_run <= skip_arm;
        skip_arm <= 1'b0;
      end
      if (ret_trace) skip_arm <= 1'b1;
    end
  end

  // R2
  svc_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(svc_go));

  // R3
  svc_fetch_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fetch_go && (svc_go != '0)));

  // R4
  end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (fetch_go || (svc_go != '0)));

  // R5
  fast_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (svc_go[3] || svc_go[4]) |-> !fast_run);

  // R7
  trace_skip_chk: assert property (@(posedge clk) disable iff (rst)
    svc_go[0] |-> !skip_run);

  // R8
  tbit_keep_chk: assert property (@(posedge clk) disable iff (rst)
    psw_we |-> (psw_next[TBIT] == $past(psw_now[TBIT])));

  // R9
  psw_cause_chk: assert property (@(posedge clk) disable iff (rst)
    psw_we |-> $past(dest_wr && dest_psw && !op_nodst));

  // R10
  start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(chk_start));

  logic unused_ok;
  assign unused_ok = ^dest_data;
endmodule

bind exc_check_ctrl exc_check_ctrl_chk #(.W(W), .TBIT(TBIT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .chk_start (chk_start),
  .fast_mode (fast_mode),
  .ret_trace (ret_trace),
  .dest_wr   (dest_wr),
  .dest_psw  (dest_psw),
  .op_nodst  (op_nodst),
  .dest_data (dest_data),
  .psw_now   (psw_now),
  .svc_go    (svc_go),
  .fetch_go  (fetch_go),
  .busy      (busy),
  .psw_we    (psw_we),
  .psw_next  (psw_next)
);

// File: tb/exc_check_ctrl_bench.sv
module exc_check_ctrl_bench;
  localparam int W = 16;
  localparam int NVEC = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chk_start = 1'b0, trace_pend = 1'b0, irq_pend = 1'b0, halt_pend = 1'b0;
  logic oddpc_err = 1'b0, stack_err = 1'b0, fast_mode = 1'b0, ret_trace = 1'b0;
  logic dest_wr = 1'b0, dest_psw = 1'b0, op_nodst = 1'b0;
  logic [W-1:0] dest_data = '0, psw_now = '0;
  logic [4:0] svc_go;
  logic fetch_go, busy, psw_we;
  logic [W-1:0] psw_next;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  exc_check_ctrl u_exc_check_ctrl (
    .clk(clk), .rst(rst), .chk_start(chk_start), .trace_pend(trace_pend),
    .irq_pend(irq_pend), .halt_pend(halt_pend), .oddpc_err(oddpc_err),
    .stack_err(stack_err), .fast_mode(fast_mode), .ret_trace(ret_trace),
    .dest_wr(dest_wr), .dest_psw(dest_psw), .op_nodst(op_nodst),
    .dest_data(dest_data), .psw_now(psw_now), .svc_go(svc_go),
    .fetch_go(fetch_go), .busy(busy), .psw_we(psw_we), .psw_next(psw_next)
  );

  // {ret_trace, fast, cond[4:0] = stack,odd,halt,irq,trace, exp_svc[4:0], exp_fetch, exp_lat[2:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    16'b0_0_00000_00000_1_101,
    16'b0_0_11111_00001_0_001,
    16'b0_0_10000_10000_0_101,
    16'b0_1_11000_00000_1_011,
    16'b0_1_01100_00100_0_011,
    16'b1_0_00001_00000_1_100,
    16'b1_0_00011_00010_0_001,
    16'b1_1_00001_00000_1_010,
    16'b0_0_01000_01000_0_100,
    16'b0_0_00010_00010_0_010
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Priority model: returns the dispatch vector, fetch flag and latency
  task automatic model(input logic [4:0] c, input bit f, input bit sk,
                       output logic [4:0] s, output bit fg, output int lat);
    logic [4:0] en;
    en = {~f, ~f, 1'b1, 1'b1, ~sk};
    s = '0; fg = 1'b0; lat = 0;
    for (int i = 0; i < 5; i++) begin
      if (en[i] && s == '0) begin
        lat++;
        if (c[i]) s = 5'(1) << i;
      end
    end
    if (s == '0) fg = 1'b1;
  endtask

  task automatic pulse_ret();
    @(negedge clk) ret_trace = 1'b1;
    @(negedge clk) ret_trace = 1'b0;
  endtask

  task automatic run_walk(input logic [4:0] c, input bit f,
                          output logic [4:0] s, output bit fg, output int lat);
    @(negedge clk);
    {stack_err, oddpc_err, halt_pend, irq_pend, trace_pend} = c;
    fast_mode = f;
    chk_start = 1'b1;
    @(negedge clk) chk_start = 1'b0;
    s = '0; fg = 1'b0; lat = 0;
    for (int k = 1; k <= 8; k++) begin
      if (lat == 0) begin
        @(negedge clk);
        if (svc_go != '0 || fetch_go) begin
          s = svc_go; fg = fetch_go; lat = k;
        end
      end
    end
    @(negedge clk);
    check(svc_go == '0 && !fetch_go && !busy, "R4", "pulse width", svc_go, 0);
  endtask

  initial begin : watchdog
    for (int n = 0; n < 100000; n++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [4:0] s, es;
    bit fg, efg;
    int lat, elat;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(svc_go == '0 && !fetch_go && !busy && !psw_we, "R1", "reset state",
          {svc_go, fetch_go, busy, psw_we}, 0);

    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][15]) pulse_ret();
      run_walk(VEC[v][13:9], VEC[v][14], s, fg, lat);
      check(s == VEC[v][8:4], "R2", "table dispatch", s, VEC[v][8:4]);
      check(fg == VEC[v][3], "R3", "table fetch", fg, VEC[v][3]);
      check(lat == int'(VEC[v][2:0]), "R4", "table latency", lat, VEC[v][2:0]);
    end

    // Exhaustive: every condition combination, both modes, with and without skip
    for (int sk = 0; sk < 2; sk++) begin
      for (int f = 0; f < 2; f++) begin
        for (int c = 0; c < 32; c++) begin
          if (sk == 1) pulse_ret();
          model(5'(c), f[0], sk[0], es, efg, elat);
          run_walk(5'(c), f[0], s, fg, lat);
          check(s == es && fg == efg, "R2 R5 R7", "dispatch", {s, fg}, {es, efg});
          check(lat == elat, "R4 R5", "latency", lat, elat);
        end
      end
    end

    // R7: skip applies to one walk only
    pulse_ret();
    run_walk(5'b00001, 1'b0, s, fg, lat);
    check(fg && lat == 4, "R7", "skip walk", lat, 4);
    run_walk(5'b00001, 1'b0, s, fg, lat);
    check(s == 5'b00001 && lat == 1, "R7", "trace resumes", s, 1);

    // R6: bypassed odd-PC not remembered
    run_walk(5'b01000, 1'b1, s, fg, lat);
    check(fg && lat == 3, "R6", "bypassed walk", lat, 3);
    run_walk(5'b00000, 1'b0, s, fg, lat);
    check(fg && s == '0 && lat == 5, "R6", "no latched dispatch", s, 0);

    // R10: second start while busy ignored
    @(negedge clk);
    {stack_err, oddpc_err, halt_pend, irq_pend, trace_pend} = '0;
    fast_mode = 1'b0;
    chk_start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(busy, "R10", "busy mid walk", busy, 1);
    @(negedge clk) chk_start = 1'b0;
    lat = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (fetch_go || svc_go != '0) lat++;
    end
    check(lat == 1 && !busy, "R10", "single end pulse", lat, 1);

    // R8 / R9: status word guard
    @(negedge clk);
    dest_wr = 1'b1; dest_psw = 1'b1; op_nodst = 1'b0;
    psw_now = 16'h0010; dest_data = 16'h0000;
    @(negedge clk);
    check(psw_we && psw_next == 16'h0010, "R8", "keep set T", psw_next, 16'h0010);
    psw_now = 16'h0000; dest_data = 16'hFFFF;
    @(negedge clk);
    check(psw_we && psw_next == 16'hFFEF, "R8", "keep clear T", psw_next, 16'hFFEF);
    op_nodst = 1'b1; dest_data = 16'h1234;
    @(negedge clk);
    check(!psw_we && psw_next == 16'hFFEF, "R9", "no-dest class", psw_we, 0);
    op_nodst = 1'b0; dest_psw = 1'b0;
    @(negedge clk);
    check(!psw_we && psw_next == 16'hFFEF, "R9", "other destination", psw_we, 0);
    dest_wr = 1'b0;
    @(negedge clk);
    check(!psw_we, "R9", "idle", psw_we, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule